// File: doc/BRIEF.md
# Four-Channel Quadrature Up-Mixer with Cascade Summer

This block takes four interpolated baseband sample streams, one per channel, and moves each to its own carrier. Every channel owns a 32-bit phase accumulator that drives an eight-point sine/cosine oscillator, a 16-bit phase offset and an unsigned 8-bit gain. Each channel's input may be complex or real. In real mode the quadrature input is taken as zero. After the complex multiply and the gain scaling, the four channel results are added together with a 22-bit cascade word from an upstream device of the same kind. The total is clamped to 22 bits and presented either as a complex pair or as a real-only result.

Frequency and phase-offset words are written through a small configuration port into per-channel holding registers. They reach the oscillators only when the shared sync input pulses. That pulse also restarts every accumulator from zero, so all channels change carrier and line up their phase on the same clock. This is what beam steering and frequency-hop schedules need. Gain words take effect at once. A clock enable qualifies every sample. When it is low, the oscillators and the whole datapath hold their state.

Top module: `duc_mix_top`

## Requirements
- R1: While reset is asserted, and right after it, out_i and out_q are zero. All accumulators, gains, held words and active words reset to zero.
- R2: The oscillator index is bits [15:13] of (accumulator bits [31:16] + active phase offset), taken modulo 2^16. Cosine by index 0..7 is 127, 90, 0, -90, -127, -90, 0, 90. Sine at index k equals cosine at index (k-2) mod 8.
- R3: Each channel forms re = I*cos - Q*sin and im = I*sin + Q*cos. When in_cplx[k] is 0, Q is treated as zero for channel k.
- R4: The channel output is floor(mix * gain / 4096), clamped to the signed 20-bit range. A gain write (cfg_sel 2, cfg_data[7:0]) is used from the next edge on.
- R5: out_i is casc_i plus the four real channel results, clamped to [-2097152, 2097151]. out_q is formed the same way from casc_q and the imaginary results.
- R6: When cplx_out is 0, out_q is zero and casc_q has no effect.
- R7: Frequency writes (cfg_sel 0, all 32 bits) and phase writes (cfg_sel 1, cfg_data[15:0]) go to holding registers and have no effect until sync. On sync, every channel copies its held words to its active words and clears its accumulator on the same edge. If a write and a sync fall on the same edge, the sync copies the old held word.
- R8: On every enabled edge without sync, each accumulator adds its active frequency word, modulo 2^32.
- R9: When en is 0, accumulators, datapath registers and outputs hold their values. Configuration writes and sync still act.
- R10: A sample presented before enabled edge n reaches the output after enabled edge n+2. The cascade and cplx_out values used are the ones present at edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sample clock enable |
| sync | input | 1 | Apply held frequency/phase words and clear accumulators |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel selected by the write |
| cfg_sel | input | 2 | 0 frequency, 1 phase offset, 2 gain, 3 no effect |
| cfg_data | input | 32 | Write data |
| in_cplx | input | 4 | Per-channel complex input flag |
| in_i | input | 64 | In-phase inputs, channel k at bits [16k+15:16k] |
| in_q | input | 64 | Quadrature inputs, same packing |
| cplx_out | input | 1 | 1 complex output, 0 real output |
| casc_i | input | 22 | Cascade in-phase input |
| casc_q | input | 22 | Cascade quadrature input |
| out_i | output | 22 | Summed in-phase output |
| out_q | output | 22 | Summed quadrature output, zero in real mode |

## Verification
The assertions assume that reset is driven low from time zero. They also assume that sync, en and the mode inputs are clean, single-valued levels at each rising edge, because the hold, clear and real-mode properties read them directly as antecedents. The stimulus changes every input only on falling edges. It drives full-scale and random signed samples, random gains and frequencies, sync pulses that sometimes coincide with writes or with a low enable, and cascade words across the whole 22-bit range, so the clamping paths are reached without any input leaving its declared width.

// File: rtl/duc_mix_pkg.sv
`timescale 1ns/1ps
package duc_mix_pkg;

  // Oscillator resolution: eight phase points, 8-bit signed amplitude.
  localparam int OSC_AW = 3;
  localparam int OSC_W  = 8;

  typedef enum logic [1:0] {
    CFG_FREQ  = 2'd0,
    CFG_PHASE = 2'd1,
    CFG_GAIN  = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;

  // Cosine amplitude at each of the eight phase points.
  function automatic logic signed [OSC_W-1:0] osc_cos(input logic [OSC_AW-1:0] k);
    logic signed [OSC_W-1:0] v;
    case (k)
      3'd0:    v = 8'sd127;
      3'd1:    v = 8'sd90;
      3'd2:    v = 8'sd0;
      3'd3:    v = -8'sd90;
      3'd4:    v = -8'sd127;
      3'd5:    v = -8'sd90;
      3'd6:    v = 8'sd0;
      default: v = 8'sd90;
    endcase
    return v;
  endfunction

  // Sine lags cosine by a quarter turn (two points).
  function automatic logic signed [OSC_W-1:0] osc_sin(input logic [OSC_AW-1:0] k);
    return osc_cos(k - OSC_AW'(2));
  endfunction

endpackage

// File: rtl/duc_mix_nco.sv
`timescale 1ns/1ps
module duc_mix_nco
  import duc_mix_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OFS_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    sync,
  input  logic                    wr_freq,
  input  logic                    wr_phase,
  input  logic [ACC_W-1:0]        wr_data,
  output logic signed [OSC_W-1:0] cos_o,
  output logic signed [OSC_W-1:0] sin_o,
  output logic [ACC_W-1:0]        acc_o,
  output logic [ACC_W-1:0]        freq_o
);

  localparam int IDX_SHIFT = OFS_W - OSC_AW;

  logic [ACC_W-1:0] acc_q, acc_n;
  logic [ACC_W-1:0] fhold_q, fhold_n;
  logic [ACC_W-1:0] fact_q, fact_n;
  logic [OFS_W-1:0] phold_q, phold_n;
  logic [OFS_W-1:0] pact_q, pact_n;
  logic [OFS_W-1:0] ptr;
  logic [OSC_AW-1:0] idx;

  // Next-state: sync wins over accumulation; writes only touch holding words.
  always_comb begin
    acc_n   = acc_q;
    fact_n  = fact_q;
    pact_n  = pact_q;
    fhold_n = fhold_q;
    phold_n = phold_q;
    if (sync) begin
      acc_n  = '0;
      fact_n = fhold_q;
      pact_n = phold_q;
    end else if (en) begin
      acc_n = acc_q + fact_q;
    end
    if (wr_freq)  fhold_n = wr_data;
    if (wr_phase) phold_n = wr_data[OFS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      fact_q  <= '0;
      pact_q  <= '0;
      fhold_q <= '0;
      phold_q <= '0;
    end else begin
      acc_q   <= acc_n;
      fact_q  <= fact_n;
      pact_q  <= pact_n;
      fhold_q <= fhold_n;
      phold_q <= phold_n;
    end
  end

  // Offset is applied to the top of the accumulator before the lookup.
  always_comb begin
    ptr   = OFS_W'(acc_q >> (ACC_W - OFS_W)) + pact_q;
    idx   = OSC_AW'(ptr >> IDX_SHIFT);
    cos_o = osc_cos(idx);
    sin_o = osc_sin(idx);
  end

  assign acc_o  = acc_q;
  assign freq_o = fact_q;

endmodule

// File: rtl/duc_mix_chan.sv
`timescale 1ns/1ps
module duc_mix_chan
  import duc_mix_pkg::*;
#(
  parameter int IN_W       = 16,
  parameter int ACC_W      = 32,
  parameter int OFS_W      = 16,
  parameter int GAIN_W     = 8,
  parameter int GAIN_SHIFT = 12,
  parameter int CH_W       = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sync,
  input  logic              cfg_hit,
  input  logic [1:0]        cfg_sel,
  input  logic [ACC_W-1:0]  cfg_data,
  input  logic [IN_W-1:0]   in_i,
  input  logic [IN_W-1:0]   in_q,
  input  logic              in_cplx,
  output logic [CH_W-1:0]   ch_re,
  output logic [CH_W-1:0]   ch_im,
  output logic [ACC_W-1:0]  acc_o,
  output logic [ACC_W-1:0]  freq_o
);

  localparam int PROD_W  = IN_W + OSC_W;
  localparam int MIX_W   = PROD_W + 1;
  localparam int GPROD_W = MIX_W + GAIN_W + 1;

  localparam logic signed [GPROD_W-1:0] CH_MAX =
    $signed({{(GPROD_W-CH_W+1){1'b0}}, {(CH_W-1){1'b1}}});
  localparam logic signed [GPROD_W-1:0] CH_MIN = ~CH_MAX;

  logic signed [OSC_W-1:0] osc_c, osc_s;
  logic wr_freq, wr_phase, wr_gain;

  assign wr_freq  = cfg_hit && (cfg_sel == CFG_FREQ);
  assign wr_phase = cfg_hit && (cfg_sel == CFG_PHASE);
  assign wr_gain  = cfg_hit && (cfg_sel == CFG_GAIN);

  duc_mix_nco #(
    .ACC_W (ACC_W),
    .OFS_W (OFS_W)
  ) u_nco (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .sync     (sync),
    .wr_freq  (wr_freq),
    .wr_phase (wr_phase),
    .wr_data  (cfg_data),
    .cos_o    (osc_c),
    .sin_o    (osc_s),
    .acc_o    (acc_o),
    .freq_o   (freq_o)
  );

  logic [GAIN_W-1:0]       gain_q, gain_n;
  logic signed [MIX_W-1:0] mre_q, mre_n, mim_q, mim_n;
  logic [CH_W-1:0]         cre_q, cre_n, cim_q, cim_n;

  logic signed [IN_W-1:0]    si, sq;
  logic signed [PROD_W-1:0]  p_ic, p_qs, p_is, p_qc;
  logic signed [GPROD_W-1:0] g_re, g_im, sh_re, sh_im;

  function automatic logic [CH_W-1:0] clamp_ch(input logic signed [GPROD_W-1:0] v);
    if (v > CH_MAX)      return CH_MAX[CH_W-1:0];
    else if (v < CH_MIN) return CH_MIN[CH_W-1:0];
    else                 return v[CH_W-1:0];
  endfunction

  // Stage A: complex multiply by the oscillator.
  always_comb begin
    si    = $signed(in_i);
    sq    = in_cplx ? $signed(in_q) : '0;
    p_ic  = si * osc_c;
    p_qs  = sq * osc_s;
    p_is  = si * osc_s;
    p_qc  = sq * osc_c;
    mre_n = MIX_W'(p_ic) - MIX_W'(p_qs);
    mim_n = MIX_W'(p_is) + MIX_W'(p_qc);
  end

  // Stage B: unsigned gain, arithmetic shift, clamp.
  always_comb begin
    g_re  = mre_q * $signed({1'b0, gain_q});
    g_im  = mim_q * $signed({1'b0, gain_q});
    sh_re = g_re >>> GAIN_SHIFT;
    sh_im = g_im >>> GAIN_SHIFT;
    cre_n = clamp_ch(sh_re);
    cim_n = clamp_ch(sh_im);
    gain_n = wr_gain ? cfg_data[GAIN_W-1:0] : gain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
      mre_q  <= '0;
      mim_q  <= '0;
      cre_q  <= '0;
      cim_q  <= '0;
    end else begin
      gain_q <= gain_n;
      if (en) begin
        mre_q <= mre_n;
        mim_q <= mim_n;
        cre_q <= cre_n;
        cim_q <= cim_n;
      end
    end
  end

  assign ch_re = cre_q;
  assign ch_im = cim_q;

endmodule

// File: rtl/duc_mix_sum.sv
`timescale 1ns/1ps
module duc_mix_sum #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 20,
  parameter int OUT_W  = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    cplx_out,
  input  logic [NUM_CH*CH_W-1:0]  ch_re_all,
  input  logic [NUM_CH*CH_W-1:0]  ch_im_all,
  input  logic [OUT_W-1:0]        casc_i,
  input  logic [OUT_W-1:0]        casc_q,
  output logic [OUT_W-1:0]        out_i,
  output logic [OUT_W-1:0]        out_q
);

  localparam int SUM_W = OUT_W + $clog2(NUM_CH) + 1;

  localparam logic signed [SUM_W-1:0] SUM_MAX =
    $signed({{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
  localparam logic signed [SUM_W-1:0] SUM_MIN = ~SUM_MAX;

  logic signed [SUM_W-1:0] sum_re, sum_im;
  logic [OUT_W-1:0] oi_q, oi_n, oq_q, oq_n;

  function automatic logic [OUT_W-1:0] clamp_out(input logic signed [SUM_W-1:0] v);
    if (v > SUM_MAX)      return SUM_MAX[OUT_W-1:0];
    else if (v < SUM_MIN) return SUM_MIN[OUT_W-1:0];
    else                  return v[OUT_W-1:0];
  endfunction

  always_comb begin
    sum_re = SUM_W'($signed(casc_i));
    sum_im = SUM_W'($signed(casc_q));
    for (int k = 0; k < NUM_CH; k++) begin
      sum_re = sum_re + SUM_W'($signed(ch_re_all[k*CH_W +: CH_W]));
      sum_im = sum_im + SUM_W'($signed(ch_im_all[k*CH_W +: CH_W]));
    end
    oi_n = clamp_out(sum_re);
    oq_n = cplx_out ? clamp_out(sum_im) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oi_q <= '0;
      oq_q <= '0;
    end else if (en) begin
      oi_q <= oi_n;
      oq_q <= oq_n;
    end
  end

  assign out_i = oi_q;
  assign out_q = oq_q;

endmodule

// File: rtl/duc_mix_top.sv
`timescale 1ns/1ps
module duc_mix_top #(
  parameter int NUM_CH     = 4,
  parameter int IN_W       = 16,
  parameter int ACC_W      = 32,
  parameter int OFS_W      = 16,
  parameter int GAIN_W     = 8,
  parameter int GAIN_SHIFT = 12,
  parameter int CH_W       = 20,
  parameter int OUT_W      = 22,
  localparam int CH_AW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    sync,
  input  logic                    cfg_we,
  input  logic [CH_AW-1:0]        cfg_ch,
  input  logic [1:0]              cfg_sel,
  input  logic [ACC_W-1:0]        cfg_data,
  input  logic [NUM_CH-1:0]       in_cplx,
  input  logic [NUM_CH*IN_W-1:0]  in_i,
  input  logic [NUM_CH*IN_W-1:0]  in_q,
  input  logic                    cplx_out,
  input  logic [OUT_W-1:0]        casc_i,
  input  logic [OUT_W-1:0]        casc_q,
  output logic [OUT_W-1:0]        out_i,
  output logic [OUT_W-1:0]        out_q
);

  logic [NUM_CH*CH_W-1:0]  ch_re_all, ch_im_all;
  logic [NUM_CH*ACC_W-1:0] acc_all, freq_all;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic hit;
    assign hit = cfg_we && (cfg_ch == CH_AW'(k));

    duc_mix_chan #(
      .IN_W       (IN_W),
      .ACC_W      (ACC_W),
      .OFS_W      (OFS_W),
      .GAIN_W     (GAIN_W),
      .GAIN_SHIFT (GAIN_SHIFT),
      .CH_W       (CH_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .sync     (sync),
      .cfg_hit  (hit),
      .cfg_sel  (cfg_sel),
      .cfg_data (cfg_data),
      .in_i     (in_i[k*IN_W +: IN_W]),
      .in_q     (in_q[k*IN_W +: IN_W]),
      .in_cplx  (in_cplx[k]),
      .ch_re    (ch_re_all[k*CH_W +: CH_W]),
      .ch_im    (ch_im_all[k*CH_W +: CH_W]),
      .acc_o    (acc_all[k*ACC_W +: ACC_W]),
      .freq_o   (freq_all[k*ACC_W +: ACC_W])
    );
  end

  duc_mix_sum #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .OUT_W  (OUT_W)
  ) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cplx_out  (cplx_out),
    .ch_re_all (ch_re_all),
    .ch_im_all (ch_im_all),
    .casc_i    (casc_i),
    .casc_q    (casc_q),
    .out_i     (out_i),
    .out_q     (out_q)
  );

endmodule

// File: rtl/duc_mix_chk.sv
`timescale 1ns/1ps
module duc_mix_chk #(
  parameter int NUM_CH = 4,
  parameter int ACC_W  = 32,
  parameter int OUT_W  = 22
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic                    sync,
  input logic                    cplx_out,
  input logic [OUT_W-1:0]        out_i,
  input logic [OUT_W-1:0]        out_q,
  input logic [NUM_CH*ACC_W-1:0] acc_all,
  input logic [NUM_CH*ACC_W-1:0] freq_all
);

  // R9: outputs frozen across a disabled edge
  a_r9_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(out_i) && $stable(out_q)));

  // R9: accumulators frozen when neither enable nor sync
  a_r9_hold_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !sync) |=> $stable(acc_all));

  // R6: real mode forces quadrature output to zero
  a_r6_real_q_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cplx_out) |=> (out_q == '0));

  // R7: sync restarts every accumulator
  a_r7_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (acc_all == '0));

  // R7: active frequency words change only on sync
  a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(freq_all));

  // R8: channel 0 accumulator advances by its active word
  a_r8_acc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sync) |=> (acc_all[ACC_W-1:0] ==
      $past(acc_all[ACC_W-1:0]) + $past(freq_all[ACC_W-1:0])));

endmodule

bind duc_mix_top duc_mix_chk #(
  .NUM_CH (NUM_CH),
  .ACC_W  (ACC_W),
  .OUT_W  (OUT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .sync     (sync),
  .cplx_out (cplx_out),
  .out_i    (out_i),
  .out_q    (out_q),
  .acc_all  (acc_all),
  .freq_all (freq_all)
);

// File: tb/duc_mix_top_tb.sv
`timescale 1ns/1ps
module duc_mix_top_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic en, sync, cfg_we, cplx_out;
  logic [1:0]  cfg_ch, cfg_sel;
  logic [31:0] cfg_data;
  logic [3:0]  in_cplx;
  logic [63:0] in_i, in_q;
  logic [21:0] casc_i, casc_q;
  logic [21:0] out_i, out_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  duc_mix_top u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .sync(sync),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .in_cplx(in_cplx), .in_i(in_i), .in_q(in_q), .cplx_out(cplx_out),
    .casc_i(casc_i), .casc_q(casc_q), .out_i(out_i), .out_q(out_q)
  );

  // ---------------- reference model (from the requirements) ----------------
  logic [31:0] m_acc [4];
  logic [31:0] m_fa  [4];
  logic [31:0] m_fs  [4];
  logic [15:0] m_pa  [4];
  logic [15:0] m_ps  [4];
  logic [7:0]  m_g   [4];
  longint m_mre [4];
  longint m_mim [4];
  longint m_cre [4];
  longint m_cim [4];
  longint m_oi, m_oq;

  function automatic longint ref_cos(input int k);   // R2 table
    case (k & 7)
      0: return 127;  1: return 90;   2: return 0;   3: return -90;
      4: return -127; 5: return -90;  6: return 0;   default: return 90;
    endcase
  endfunction

  function automatic longint clampv(input longint v, input int w);
    longint hi, lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 4; k++) begin
      m_acc[k] = '0; m_fa[k] = '0; m_fs[k] = '0; m_pa[k] = '0; m_ps[k] = '0;
      m_g[k] = '0; m_mre[k] = 0; m_mim[k] = 0; m_cre[k] = 0; m_cim[k] = 0;
    end
    m_oi = 0; m_oq = 0;
  endtask

  // Predict the effect of the coming rising edge with the inputs now driven.
  task automatic model_edge();
    longint n_mre [4];
    longint n_mim [4];
    longint n_cre [4];
    longint n_cim [4];
    longint sre, sim;
    sre = longint'($signed(casc_i));
    sim = longint'($signed(casc_q));
    for (int k = 0; k < 4; k++) begin
      logic [15:0] ptr;
      int idx;
      longint c, s, ii, qq;
      ptr = m_acc[k][31:16] + m_pa[k];
      idx = int'(ptr[15:13]);
      c = ref_cos(idx);
      s = ref_cos(idx + 6);
      ii = longint'($signed(in_i[k*16 +: 16]));
      qq = in_cplx[k] ? longint'($signed(in_q[k*16 +: 16])) : 0;
      n_mre[k] = ii * c - qq * s;
      n_mim[k] = ii * s + qq * c;
      n_cre[k] = clampv((m_mre[k] * longint'(m_g[k])) >>> 12, 20);
      n_cim[k] = clampv((m_mim[k] * longint'(m_g[k])) >>> 12, 20);
      sre += m_cre[k];
      sim += m_cim[k];
    end
    if (en) begin
      for (int k = 0; k < 4; k++) begin
        m_mre[k] = n_mre[k]; m_mim[k] = n_mim[k];
        m_cre[k] = n_cre[k]; m_cim[k] = n_cim[k];
      end
      m_oi = clampv(sre, 22);
      m_oq = cplx_out ? clampv(sim, 22) : 0;
    end
    for (int k = 0; k < 4; k++) begin
      if (sync) begin
        m_acc[k] = '0; m_fa[k] = m_fs[k]; m_pa[k] = m_ps[k];
      end else if (en) begin
        m_acc[k] = m_acc[k] + m_fa[k];
      end
    end
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: m_fs[cfg_ch] = cfg_data;
        2'd1: m_ps[cfg_ch] = cfg_data[15:0];
        2'd2: m_g[cfg_ch]  = cfg_data[7:0];
        default: ;
      endcase
    end
  endtask

  // ---------------- checking helpers ----------------
  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_model(input string req);
    chk(req, "out_i", longint'($signed(out_i)), m_oi);
    chk(req, "out_q", longint'($signed(out_q)), m_oq);
  endtask

  task automatic step(input string req);
    model_edge();
    @(negedge clk);
    cmp_model(req);
  endtask

  task automatic idle_inputs();
    en = 1'b1; sync = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_sel = 2'd3;
    cfg_data = '0; in_cplx = '0; in_i = '0; in_q = '0; cplx_out = 1'b1;
    casc_i = '0; casc_q = '0;
  endtask

  task automatic write_cfg(input int ch, input int sel, input logic [31:0] d, input string req);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_data = d;
    step(req);
    cfg_we = 1'b0; cfg_sel = 2'd3;
  endtask

  task automatic do_sync(input string req);
    sync = 1'b1;
    step(req);
    sync = 1'b0;
  endtask

  // Zero frequency and phase everywhere, set gains, apply with sync.
  task automatic setup_static(input logic [7:0] g0, input logic [7:0] gx, input string req);
    for (int k = 0; k < 4; k++) begin
      write_cfg(k, 0, 32'd0, req);
      write_cfg(k, 1, 32'd0, req);
      write_cfg(k, 2, {24'd0, (k == 0) ? g0 : gx}, req);
    end
    do_sync(req);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int r;
    r = int'($urandom(32'd741));
    idle_inputs();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", "out_i in reset", longint'($signed(out_i)), 0);
    chk("R1", "out_q in reset", longint'($signed(out_q)), 0);
    rst_n = 1'b1;
    for (int n = 0; n < 4; n++) step("R1");

    // R10: impulse on channel 0, cos=127, gain 128 -> 4096*127*128/4096 = 16256
    setup_static(8'd128, 8'd0, "R10");
    for (int n = 0; n < 4; n++) step("R10");
    in_i[15:0] = 16'd4096;
    step("R10");
    chk("R10", "one edge after impulse", longint'($signed(out_i)), 0);
    in_i = '0;
    step("R10");
    chk("R10", "two edges after impulse", longint'($signed(out_i)), 0);
    step("R10");
    chk("R10", "three edges after impulse", longint'($signed(out_i)), 16256);
    step("R10");
    chk("R10", "four edges after impulse", longint'($signed(out_i)), 0);

    // R7: held frequency has no effect before sync
    in_i[15:0] = 16'd4096;
    write_cfg(0, 0, 32'h4000_0000, "R7");
    write_cfg(0, 1, 32'h0000_2000, "R7");
    for (int n = 0; n < 5; n++) step("R7");
    chk("R7", "output steady before sync", longint'($signed(out_i)), 16256);
    do_sync("R7");
    for (int n = 0; n < 8; n++) step("R8");   // R8: quarter-turn steps

    // R5: positive and negative clamping
    in_i = '0;
    setup_static(8'd255, 8'd255, "R5");
    in_i = {4{16'sh7FFF}};
    casc_i = 22'h1FFFFF;
    for (int n = 0; n < 4; n++) step("R5");
    chk("R5", "positive clamp", longint'($signed(out_i)), 2097151);
    in_i = {4{16'sh8000}};
    casc_i = 22'h200000;
    for (int n = 0; n < 4; n++) step("R5");
    chk("R5", "negative clamp", longint'($signed(out_i)), -2097152);

    // R4: channel value without clamp: -32768*127*255/4096 = -259080 each
    casc_i = '0;
    for (int n = 0; n < 3; n++) step("R4");
    chk("R4", "gain scaling sum", longint'($signed(out_i)), -1036320);

    // R6: real mode, quadrature and cascade_q ignored
    in_cplx = 4'hF; in_q = {4{16'sd1234}};
    cplx_out = 1'b0; casc_q = 22'd12345;
    for (int n = 0; n < 4; n++) step("R6");
    chk("R6", "out_q in real mode", longint'($signed(out_q)), 0);

    // R9: enable low holds output while inputs move
    begin
      longint held;
      held = longint'($signed(out_i));
      en = 1'b0; in_i = {4{16'sd77}}; casc_i = 22'd999;
      for (int n = 0; n < 4; n++) step("R9");
      chk("R9", "output held while disabled", longint'($signed(out_i)), held);
      en = 1'b1;
    end

    // R2/R3: constrained random run
    for (int n = 0; n < 3000; n++) begin
      en       = ($urandom_range(7) != 0);
      sync     = ($urandom_range(63) == 0);
      cfg_we   = ($urandom_range(3) == 0);
      cfg_ch   = 2'($urandom_range(3));
      cfg_sel  = 2'($urandom_range(3));
      cfg_data = $urandom();
      if ($urandom_range(31) == 0) cplx_out = ~cplx_out;
      in_cplx  = 4'($urandom_range(15));
      in_i     = {$urandom(), $urandom()};
      in_q     = {$urandom(), $urandom()};
      casc_i   = 22'($urandom());
      casc_q   = 22'($urandom());
      step((n % 2 == 0) ? "R2" : "R3");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule